// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data buses, A and B. It can pass data live from one bus to the other, or drive a value held in a register. There is one register for each direction, and each register has its own rising-edge capture clock. An active-low output enable and a direction input decide which bus is driven, if either. For the driven side, a select input chooses between the live value on the opposite bus and the stored word.

Each pad is modelled as three signals: an input, an output and an output enable. A wrapper outside the block resolves the tri-state. The registers always hold true bus data. A parameter gives an inverting variant, which complements only the data leaving the block.

A shared asynchronous active-low reset clears both registers so that simulation starts from a known state. The registers keep capturing when both buses are isolated. This lets the block hold an A word and a B word while it drives neither bus.

Top module: `bus_xcvr_reg`

## Requirements
- R1: When oe_n is 1, a_oe and b_oe are both 0, whatever the other controls are.
- R2: When oe_n is 0, dir_a2b = 1 gives b_oe = 1 and a_oe = 0, and dir_a2b = 0 gives a_oe = 1 and b_oe = 0.
- R3: a_oe and b_oe are never 1 together.
- R4: On each rising edge of cap_ab_clk, the A-to-B register loads a_in. This happens whether or not either bus is driven.
- R5: On each rising edge of cap_ba_clk, the B-to-A register loads b_in. This happens whether or not either bus is driven, and a cap_ab_clk edge leaves this register unchanged.
- R6: While B is driven, sel_ab_stored = 0 puts the live a_in on b_out in the same cycle, and sel_ab_stored = 1 puts the A-to-B register on b_out.
- R7: While A is driven, sel_ba_stored = 0 puts the live b_in on a_out in the same cycle, and sel_ba_stored = 1 puts the B-to-A register on a_out.
- R8: With INVERT = 1, a_out and b_out carry the bitwise complement of the selected value. The registers still store uninverted pin data, and the enables behave as with INVERT = 0.
- R9: rst_n = 0 clears both registers to all zeros at once, without waiting for a clock edge.
- R10: A capture edge on the register whose own input bus is being driven by the block loads the value the block is driving onto that bus.
- R11: A capture edge while that register's content is on the driven output makes the output show the newly captured word right after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| cap_ab_clk | input | 1 | Rising-edge capture clock of the A-to-B register |
| cap_ba_clk | input | 1 | Rising-edge capture clock of the B-to-A register |
| oe_n | input | 1 | Active-low output enable for both buses |
| dir_a2b | input | 1 | 1: drive B from the A side, 0: drive A from the B side |
| sel_ab_stored | input | 1 | 1: B gets the stored word, 0: B gets live A data |
| sel_ba_stored | input | 1 | 1: A gets the stored word, 0: A gets live B data |
| a_in | input | W | Value present on the A pins |
| a_out | output | W | Data to drive onto the A pins |
| a_oe | output | 1 | Drive enable for the A pins |
| b_in | input | W | Value present on the B pins |
| b_out | output | W | Data to drive onto the B pins |
| b_oe | output | 1 | Drive enable for the B pins |

## Verification
Two functions can fall in the same cycle. One is a register capture. The other is either driving that same register onto the output or driving the bus the register samples.

The bench provokes the first case by pulsing cap_ab_clk while B shows the stored word. It judges the case by checking that b_out shows the new A word right after the edge.

The bench provokes the second case by pulsing cap_ab_clk while A is driven from live B data, through a wrapper that loops the driven pins back into a_in. It then turns the direction around and checks that the stored word is the value the block had been driving, for both the plain and the inverting instance.

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         rst_n,
  input  logic         cap_ab_clk,
  input  logic         cap_ba_clk,
  input  logic         oe_n,
  input  logic         dir_a2b,
  input  logic         sel_ab_stored,
  input  logic         sel_ba_stored,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  localparam logic [W-1:0] INV_MASK = INVERT ? {W{1'b1}} : {W{1'b0}};

  logic [W-1:0] q_ab, q_ba;
  logic         ab_seen, ba_seen;

  always_ff @(posedge cap_ab_clk or negedge rst_n)
    if (!rst_n) begin
      q_ab    <= '0;
      ab_seen <= 1'b0;
    end else begin
      q_ab    <= a_in;
      ab_seen <= 1'b1;
    end

  always_ff @(posedge cap_ba_clk or negedge rst_n)
    if (!rst_n) begin
      q_ba    <= '0;
      ba_seen <= 1'b0;
    end else begin
      q_ba    <= b_in;
      ba_seen <= 1'b1;
    end

  assign b_oe  = !oe_n &&  dir_a2b;
  assign a_oe  = !oe_n && !dir_a2b;
  assign b_out = (sel_ab_stored ? q_ab : a_in) ^ INV_MASK;
  assign a_out = (sel_ba_stored ? q_ba : b_in) ^ INV_MASK;

  AST_AB_HOLDS_LAST: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
    (ab_seen && b_oe && sel_ab_stored) |-> (b_out == ($past(a_in) ^ INV_MASK)));  // R4
  AST_BA_HOLDS_LAST: assert property (@(posedge cap_ba_clk) disable iff (!rst_n)
    (ba_seen && a_oe && sel_ba_stored) |-> (a_out == ($past(b_in) ^ INV_MASK)));  // R5
  AST_AB_CLEARED: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
    (!ab_seen && b_oe && sel_ab_stored) |-> (b_out == INV_MASK));  // R9
  AST_BA_CLEARED: assert property (@(posedge cap_ba_clk) disable iff (!rst_n)
    (!ba_seen && a_oe && sel_ba_stored) |-> (a_out == INV_MASK));  // R9

endmodule

// File: tb/test_bus_xcvr_reg.sv
`timescale 1ns/1ps
module test_bus_xcvr_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cab, cba, oe_n, dir, sab, sba;
  logic [W-1:0] a_ext, b_ext;
  logic [W-1:0] a_out0, b_out0, a_out1, b_out1;
  logic a_oe0, b_oe0, a_oe1, b_oe1;
  wire  [W-1:0] a_pin0 = a_oe0 ? a_out0 : a_ext;
  wire  [W-1:0] b_pin0 = b_oe0 ? b_out0 : b_ext;
  wire  [W-1:0] a_pin1 = a_oe1 ? a_out1 : a_ext;
  wire  [W-1:0] b_pin1 = b_oe1 ? b_out1 : b_ext;

  bus_xcvr_reg #(.W(W), .INVERT(1'b0)) i_bus_xcvr_reg (
    .rst_n(rst_n), .cap_ab_clk(cab), .cap_ba_clk(cba), .oe_n(oe_n), .dir_a2b(dir),
    .sel_ab_stored(sab), .sel_ba_stored(sba), .a_in(a_pin0), .a_out(a_out0), .a_oe(a_oe0),
    .b_in(b_pin0), .b_out(b_out0), .b_oe(b_oe0));

  bus_xcvr_reg #(.W(W), .INVERT(1'b1)) i_bus_xcvr_reg_inv (
    .rst_n(rst_n), .cap_ab_clk(cab), .cap_ba_clk(cba), .oe_n(oe_n), .dir_a2b(dir),
    .sel_ab_stored(sab), .sel_ba_stored(sba), .a_in(a_pin1), .a_out(a_out1), .a_oe(a_oe1),
    .b_in(b_pin1), .b_out(b_out1), .b_oe(b_oe1));

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_ab();
    #1 cab = 1'b1;
    #2 cab = 1'b0;
  endtask

  task automatic pulse_ba();
    #1 cba = 1'b1;
    #2 cba = 1'b0;
  endtask

  // {oe_n,dir,sab,sba, a_ext, b_ext, pulse_ab,pulse_ba, exp_a_oe,exp_b_oe, exp_data}
  localparam logic [31:0] VEC [12] = '{
    {4'b1000, 8'h11, 8'h22, 2'b11, 2'b00, 8'h00},
    {4'b0110, 8'h33, 8'h44, 2'b00, 2'b01, 8'h11},
    {4'b0100, 8'h5A, 8'h44, 2'b00, 2'b01, 8'h5A},
    {4'b0001, 8'h33, 8'h77, 2'b00, 2'b10, 8'h22},
    {4'b0000, 8'h33, 8'hC3, 2'b00, 2'b10, 8'hC3},
    {4'b1000, 8'hA5, 8'h96, 2'b10, 2'b00, 8'h00},
    {4'b0110, 8'h00, 8'h00, 2'b00, 2'b01, 8'hA5},
    {4'b0001, 8'h00, 8'h00, 2'b00, 2'b10, 8'h22},
    {4'b0110, 8'h0F, 8'h00, 2'b10, 2'b01, 8'h0F},
    {4'b0001, 8'h00, 8'hF0, 2'b01, 2'b10, 8'hF0},
    {4'b0000, 8'h00, 8'hFF, 2'b00, 2'b10, 8'hFF},
    {4'b0100, 8'h00, 8'h66, 2'b00, 2'b01, 8'h00}
  };

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cab = 1'b0; cba = 1'b0; oe_n = 1'b1; dir = 1'b0;
    sab = 1'b0; sba = 1'b0; a_ext = '0; b_ext = '0;
    #12 rst_n = 1'b1;
    #3;
    // R1: isolation after reset
    check("R1 a_oe", W'(a_oe0), 8'h00);
    check("R1 b_oe", W'(b_oe0), 8'h00);
    // R9: cleared registers shown on both sides
    oe_n = 1'b0; dir = 1'b1; sab = 1'b1; #2;
    check("R9 b_out", b_out0, 8'h00);
    check("R9 b_out inv", b_out1, 8'hFF);
    dir = 1'b0; sba = 1'b1; #2;
    check("R9 a_out", a_out0, 8'h00);
    check("R9 a_out inv", a_out1, 8'hFF);

    for (int i = 0; i < 12; i++) begin
      logic [31:0] v;
      v = VEC[i];
      {oe_n, dir, sab, sba} = v[31:28];
      a_ext = v[27:20];
      b_ext = v[19:12];
      #1;
      if (v[11]) pulse_ab();
      if (v[10]) pulse_ba();
      #2;
      // R1 R2 R3 enables, R4 R5 capture, R6 R7 data path, R8 inverting copy, R11 capture while shown
      check("R2 a_oe", W'(a_oe0), W'(v[9]));
      check("R2 b_oe", W'(b_oe0), W'(v[8]));
      check("R8 a_oe inv", W'(a_oe1), W'(v[9]));
      check("R8 b_oe inv", W'(b_oe1), W'(v[8]));
      check("R3 exclusive", W'(a_oe0 & b_oe0), 8'h00);
      if (v[9]) begin
        check("R7 a_out", a_out0, v[7:0]);
        check("R8 a_out inv", a_out1, ~v[7:0]);
      end
      if (v[8]) begin
        check("R6 b_out", b_out0, v[7:0]);
        check("R8 b_out inv", b_out1, ~v[7:0]);
      end
    end

    // R10: capture of A while A is driven from live B
    oe_n = 1'b0; dir = 1'b0; sba = 1'b0; sab = 1'b0; b_ext = 8'h3C; a_ext = 8'h99;
    #1 pulse_ab();
    dir = 1'b1; sab = 1'b1; #2;
    check("R10 b_out", b_out0, 8'h3C);
    check("R10 b_out inv", b_out1, 8'h3C);

    // R9: asynchronous clear mid-run, no clock edge
    rst_n = 1'b0; #1;
    check("R9 async b_out", b_out0, 8'h00);
    check("R9 async b_out inv", b_out1, 8'hFF);
    rst_n = 1'b1; #2;

    // R1: isolation ignores direction and select
    oe_n = 1'b1; dir = 1'b1; #2;
    check("R1 iso b_oe", W'(b_oe0), 8'h00);
    dir = 1'b0; #2;
    check("R1 iso a_oe", W'(a_oe0), 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule